// File: doc/BRIEF.md
# Speech Parameter Register Update Unit

This block owns the parameter set that drives a speech synthesizer: one 8-bit amplitude, one 8-bit pitch period and twelve 8-bit filter coefficients, arranged as six B/F pairs. A fetch unit hands it a decoded instruction together with a repeat count. The block then asks for that instruction's operand fields one at a time, stating the width of each field it wants. It places every field into its target register by fixed rules: MSB justification with zero fill, zero expansion of unsigned B fields, replacement of the high bits only, or a blind two's-complement add.

Updates collect in a shadow copy and move to the output registers in a single cycle. A one-cycle strobe marks each move, so the synthesizer always latches a consistent set of parameters. When the extra mode is active, a full load can also carry amplitude and pitch deltas. These deltas are added again on every pitch-period tick, and the additions wrap.

Top module: `spu_param_regs`

## Requirements
- R1: After reset, amp_o is 0, pitch_o is 64, every coefficient is 0, upd_valid_o is low and ins_ready_o is high.
- R2: An instruction is taken when ins_valid_i and ins_ready_o are both high. extra_i is sampled at that point. Fields are then requested one at a time: fld_req_o is high, fld_width_o gives the width, and the field arrives right-aligned on fld_data_i, qualified by fld_valid_i. Opcode 1 asks for amplitude(8) then pitch(8). Opcode 2 asks for amplitude(8), pitch(8) and coefficients 0 to 11 (8 bits each); with extra set it then asks for an amplitude delta(8) and a pitch delta(8). Coefficient k sits on coef_o[8k+7:8k], in the order B0,F0,B1,F1,...,B5,F5.
- R3: Opcode 3 asks for amplitude(8), pitch(8), B2(3), F2(5), B3(4) and F3(6). A signed N-bit field is written as field<<(8-N), so its low bits are zero.
- R4: An unsigned N-bit B field is written as field<<(7-N), which zero-expands it to N+1 bits in the top of the register.
- R5: Opcode 3 clears the eight coefficients it does not carry. Opcode 2 replaces all twelve coefficients.
- R6: Opcode 4 asks for amplitude(8), F3(6) and F4(6). It replaces only the top 6 bits of F3 and F4 and leaves all other coefficient bits unchanged.
- R7: With extra clear, opcode 4 also clears B5 and F5. With extra set, it asks for a further 8-bit F5 field, replaces F5 and leaves B5 unchanged.
- R8: Opcode 5 asks for amplitude(4), pitch(5), B4(4) and F4(4). Each field is a signed delta. The amplitude and pitch deltas are added at bit 0. The B4 and F4 deltas are multiplied by 4 before the add. Every add is modulo 256 over the whole register.
- R9: Opcode 0 asks for no fields. It sets the amplitude to 0 and the pitch to 64, and clears all coefficients and both per-period deltas.
- R10: noise_o is high exactly when pitch_o is 0.
- R11: While extra_i is high, each period_tick_i pulse adds the stored deltas to the amplitude and pitch, modulo 256. Only opcode 2 with extra set stores deltas. Every other instruction clears them. With extra_i low, a tick has no effect.
- R12: A repeat count of 0, or opcode 6 or 7, is taken as a no-op. No field is requested, no register changes and no strobe is given.
- R13: Outputs do not change while fields are pending. upd_valid_o is high for exactly the one cycle after the last field, or after a PAUSE is taken, and rpt_o then shows the instruction's repeat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| extra_i | input | 1 | Extra mode |
| ins_valid_i | input | 1 | Instruction offered |
| ins_op_i | input | 3 | Decoded opcode |
| ins_rpt_i | input | 4 | Repeat count |
| ins_ready_o | output | 1 | Idle, can take an instruction |
| fld_req_o | output | 1 | Field requested |
| fld_width_o | output | 4 | Width of the requested field |
| fld_valid_i | input | 1 | Field present |
| fld_data_i | input | 8 | Field value, right-aligned |
| period_tick_i | input | 1 | Start of a pitch period |
| amp_o | output | 8 | Amplitude |
| pitch_o | output | 8 | Pitch period |
| coef_o | output | 96 | Twelve coefficients |
| noise_o | output | 1 | Noise excitation selected |
| rpt_o | output | 4 | Repeat count of the last update |
| upd_valid_o | output | 1 | Parameter set updated |

## Verification
The assertions assume that extra_i and period_tick_i stay low while fields are pending. They also assume that fld_valid_i is asserted only while fld_req_o is high, and that the fetch side offers exactly the width that was requested. The bench drives every input at the falling edge and raises fld_valid_i only after it has checked fld_req_o and fld_width_o. It changes extra_i only while the block is idle, and it pulses period_tick_i only between instructions.

// File: rtl/spu_pkg.sv
package spu_pkg;
  localparam int DW       = 8;
  localparam int NCOEF    = 12;
  localparam int NREG     = NCOEF + 4;
  localparam int R_AMP    = NCOEF;
  localparam int R_PITCH  = NCOEF + 1;
  localparam int R_AD     = NCOEF + 2;
  localparam int R_PD     = NCOEF + 3;
  localparam int IDX_W    = $clog2(NREG);
  localparam logic [DW-1:0] SILENT_PITCH = DW'(64);

  typedef enum logic [2:0] {
    OP_PAUSE     = 3'd0,
    OP_LOAD_PA   = 3'd1,
    OP_LOAD_ALL  = 3'd2,
    OP_LOAD_PART = 3'd3,
    OP_SET_MSB   = 3'd4,
    OP_DELTA     = 3'd5
  } op_e;

  typedef enum logic [1:0] {K_LOAD, K_UNS, K_MSB, K_DELTA} kind_e;

  typedef struct packed {
    logic [IDX_W-1:0] dst;
    logic [3:0]       width;
    kind_e            kind;
    logic [2:0]       shift;
    logic             last;
  } fld_desc_t;

  function automatic fld_desc_t mk(int dst, int w, kind_e k, int sh, logic last);
    fld_desc_t d;
    d.dst   = IDX_W'(dst);
    d.width = 4'(w);
    d.kind  = k;
    d.shift = 3'(sh);
    d.last  = last;
    return d;
  endfunction

  // field layout for each opcode, indexed by step
  function automatic fld_desc_t layout(logic [2:0] op, logic ext, logic [3:0] step);
    fld_desc_t d;
    d = mk(R_AMP, DW, K_LOAD, 0, 1'b1);
    case (op)
      OP_LOAD_PA:
        d = (step == 4'd0) ? mk(R_AMP, DW, K_LOAD, 0, 1'b0) : mk(R_PITCH, DW, K_LOAD, 0, 1'b1);
      OP_LOAD_ALL:
        if (step == 4'd0)       d = mk(R_AMP, DW, K_LOAD, 0, 1'b0);
        else if (step == 4'd1)  d = mk(R_PITCH, DW, K_LOAD, 0, 1'b0);
        else if (step <= 4'd13) d = mk(int'(step) - 2, DW, K_LOAD, 0, !ext && step == 4'd13);
        else if (step == 4'd14) d = mk(R_AD, DW, K_LOAD, 0, 1'b0);
        else                    d = mk(R_PD, DW, K_LOAD, 0, 1'b1);
      OP_LOAD_PART:
        case (step)
          4'd0:    d = mk(R_AMP, DW, K_LOAD, 0, 1'b0);
          4'd1:    d = mk(R_PITCH, DW, K_LOAD, 0, 1'b0);
          4'd2:    d = mk(4, 3, K_UNS, 0, 1'b0);
          4'd3:    d = mk(5, 5, K_LOAD, 0, 1'b0);
          4'd4:    d = mk(6, 4, K_UNS, 0, 1'b0);
          default: d = mk(7, 6, K_LOAD, 0, 1'b1);
        endcase
      OP_SET_MSB:
        case (step)
          4'd0:    d = mk(R_AMP, DW, K_LOAD, 0, 1'b0);
          4'd1:    d = mk(7, 6, K_MSB, 0, 1'b0);
          4'd2:    d = mk(9, 6, K_MSB, 0, !ext);
          default: d = mk(11, DW, K_MSB, 0, 1'b1);
        endcase
      OP_DELTA:
        case (step)
          4'd0:    d = mk(R_AMP, 4, K_DELTA, 0, 1'b0);
          4'd1:    d = mk(R_PITCH, 5, K_DELTA, 0, 1'b0);
          4'd2:    d = mk(8, 4, K_DELTA, 2, 1'b0);
          default: d = mk(9, 4, K_DELTA, 2, 1'b1);
        endcase
      default: d = mk(R_AMP, DW, K_LOAD, 0, 1'b1);
    endcase
    return d;
  endfunction
endpackage

// File: rtl/spu_field_place.sv
module spu_field_place
  import spu_pkg::*;
(
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] fld_i,
  input  logic [3:0]    width_i,
  input  kind_e         kind_i,
  input  logic [2:0]    shift_i,
  output logic [DW-1:0] new_o
);
  logic [DW-1:0] low_mask, hi_mask, fv, sx;
  logic          sign;

  always_comb begin
    low_mask = {DW{1'b1}} >> (4'(DW) - width_i);
    hi_mask  = ~({DW{1'b1}} >> width_i);
    fv       = fld_i & low_mask;
    sign     = (fv & ~(low_mask >> 1)) != '0;
    sx       = sign ? (fv | ~low_mask) : fv;
    unique case (kind_i)
      K_LOAD:  new_o = fv << (4'(DW) - width_i);
      K_UNS:   new_o = fv << (4'(DW - 1) - width_i);
      K_MSB:   new_o = (old_i & ~hi_mask) | (fv << (4'(DW) - width_i));
      default: new_o = old_i + (sx << shift_i);  // blind add, wraps
    endcase
  end
endmodule

// File: rtl/spu_seq.sv
module spu_seq
  import spu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       extra_i,
  input  logic       ins_valid_i,
  input  logic [2:0] ins_op_i,
  input  logic [3:0] ins_rpt_i,
  input  logic       fld_valid_i,
  output logic       ins_ready_o,
  output logic       fld_req_o,
  output logic [3:0] fld_width_o,
  output logic       start_o,
  output logic       pause_o,
  output logic       apply_o,
  output logic       commit_o,
  output fld_desc_t  desc_o,
  output logic [2:0] op_o,
  output logic       ext_o,
  output logic [3:0] rpt_o
);
  logic       busy_q, ext_q;
  logic [2:0] op_q;
  logic [3:0] step_q, rpt_q;
  logic       take, noop;

  assign take        = ins_valid_i && !busy_q;
  assign noop        = (ins_rpt_i == 4'd0) || (ins_op_i > OP_DELTA);
  assign pause_o     = take && !noop && ins_op_i == OP_PAUSE;
  assign start_o     = take && !noop && ins_op_i != OP_PAUSE;
  assign desc_o      = layout(op_q, ext_q, step_q);
  assign ins_ready_o = !busy_q;
  assign fld_req_o   = busy_q;
  assign fld_width_o = busy_q ? desc_o.width : 4'd0;
  assign apply_o     = busy_q && fld_valid_i;
  assign commit_o    = apply_o && desc_o.last;
  assign op_o        = op_q;
  assign ext_o       = ext_q;
  assign rpt_o       = busy_q ? rpt_q : ins_rpt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ext_q  <= 1'b0;
      op_q   <= '0;
      step_q <= '0;
      rpt_q  <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      ext_q  <= extra_i;
      op_q   <= ins_op_i;
      step_q <= '0;
      rpt_q  <= ins_rpt_i;
    end else if (apply_o) begin
      step_q <= step_q + 4'd1;
      if (commit_o) busy_q <= 1'b0;
    end
  end

  p_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_req_o |-> (fld_width_o != 4'd0 && fld_width_o <= 4'(DW)));
endmodule

// File: rtl/spu_param_regs.sv
module spu_param_regs
  import spu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              extra_i,
  input  logic              ins_valid_i,
  input  logic [2:0]        ins_op_i,
  input  logic [3:0]        ins_rpt_i,
  output logic              ins_ready_o,
  output logic              fld_req_o,
  output logic [3:0]        fld_width_o,
  input  logic              fld_valid_i,
  input  logic [DW-1:0]     fld_data_i,
  input  logic              period_tick_i,
  output logic [DW-1:0]     amp_o,
  output logic [DW-1:0]     pitch_o,
  output logic [NCOEF*DW-1:0] coef_o,
  output logic              noise_o,
  output logic [3:0]        rpt_o,
  output logic              upd_valid_o
);
  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] sh_q   [NREG];
  logic [DW-1:0] sh_next[NREG];
  logic [DW-1:0] start_val [NREG];
  logic [DW-1:0] commit_val[NREG];
  logic [DW-1:0] placed;
  logic [3:0]    rpt_q, seq_rpt;
  logic          upd_q;
  logic          start, pause, apply, commit, ext;
  logic [2:0]    op;
  fld_desc_t     desc;

  spu_seq u_seq (
    .clk_i, .rst_ni, .extra_i, .ins_valid_i, .ins_op_i, .ins_rpt_i, .fld_valid_i,
    .ins_ready_o, .fld_req_o, .fld_width_o,
    .start_o(start), .pause_o(pause), .apply_o(apply), .commit_o(commit),
    .desc_o(desc), .op_o(op), .ext_o(ext), .rpt_o(seq_rpt)
  );

  spu_field_place u_place (
    .old_i(sh_q[desc.dst]), .fld_i(fld_data_i), .width_i(desc.width),
    .kind_i(desc.kind), .shift_i(desc.shift), .new_o(placed)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign sh_next[i] = (apply && desc.dst == IDX_W'(i)) ? placed : sh_q[i];
    if (i < NCOEF) begin : g_coef
      assign start_val[i] = (ins_op_i == OP_LOAD_PART) ? '0 : regs_q[i];
      assign coef_o[i*DW +: DW] = regs_q[i];
    end else if (i == R_AD || i == R_PD) begin : g_delta
      assign start_val[i] = '0;
    end else begin : g_ap
      assign start_val[i] = regs_q[i];
    end
    if (i >= NCOEF - 2 && i < NCOEF) begin : g_b5f5
      assign commit_val[i] = (op == OP_SET_MSB && !ext) ? '0 : sh_next[i];
    end else begin : g_plain
      assign commit_val[i] = sh_next[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) sh_q[i] <= '0;
    end else if (start) begin
      for (int i = 0; i < NREG; i++) sh_q[i] <= start_val[i];
    end else if (apply) begin
      for (int i = 0; i < NREG; i++) sh_q[i] <= sh_next[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      regs_q[R_PITCH] <= SILENT_PITCH;
      rpt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= pause || commit;
      if (pause) begin
        for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        regs_q[R_PITCH] <= SILENT_PITCH;
        rpt_q <= seq_rpt;
      end else if (commit) begin
        for (int i = 0; i < NREG; i++) regs_q[i] <= commit_val[i];
        rpt_q <= seq_rpt;
      end else if (period_tick_i && extra_i) begin
        regs_q[R_AMP]   <= regs_q[R_AMP] + regs_q[R_AD];
        regs_q[R_PITCH] <= regs_q[R_PITCH] + regs_q[R_PD];
      end
    end
  end

  assign amp_o       = regs_q[R_AMP];
  assign pitch_o     = regs_q[R_PITCH];
  assign noise_o     = regs_q[R_PITCH] == '0;
  assign rpt_o       = rpt_q;
  assign upd_valid_o = upd_q;

  p_pause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && ins_ready_o && ins_op_i == OP_PAUSE && ins_rpt_i != 4'd0)
    |=> (amp_o == '0 && pitch_o == SILENT_PITCH && coef_o == '0 && upd_valid_o));

  p_noop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && ins_ready_o && (ins_rpt_i == 4'd0 || ins_op_i > OP_DELTA) && !period_tick_i)
    |=> ($stable(amp_o) && $stable(pitch_o) && $stable(coef_o) && !upd_valid_o && ins_ready_o));

  p_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld_req_o && !fld_valid_i && !period_tick_i)
    |=> ($stable(amp_o) && $stable(pitch_o) && $stable(coef_o) && !upd_valid_o));

  p_tick_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_tick_i && !extra_i && ins_ready_o && !ins_valid_i)
    |=> ($stable(amp_o) && $stable(pitch_o)));
endmodule

// File: tb/sim_spu_param_regs.sv
module sim_spu_param_regs;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        extra = 1'b0, ins_valid = 1'b0, fld_valid = 1'b0, tick = 1'b0;
  logic [2:0]  ins_op = '0;
  logic [3:0]  ins_rpt = '0;
  logic [7:0]  fld_data = '0;
  logic        ins_ready, fld_req, noise, upd_valid;
  logic [3:0]  fld_width, rpt;
  logic [7:0]  amp, pitch;
  logic [95:0] coef;

  int checks = 0, errors = 0, cyc = 0;
  int e_amp, e_pitch;
  int e_coef [12];

  always #2.5 clk = ~clk;

  spu_param_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .extra_i(extra), .ins_valid_i(ins_valid),
    .ins_op_i(ins_op), .ins_rpt_i(ins_rpt), .ins_ready_o(ins_ready),
    .fld_req_o(fld_req), .fld_width_o(fld_width), .fld_valid_i(fld_valid),
    .fld_data_i(fld_data), .period_tick_i(tick), .amp_o(amp), .pitch_o(pitch),
    .coef_o(coef), .noise_o(noise), .rpt_o(rpt), .upd_valid_o(upd_valid)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic int msbj(int v, int w); return (v << (8 - w)) & 255; endfunction
  function automatic int uexp(int v, int w); return (v << (7 - w)) & 255; endfunction
  function automatic int sx(int v, int w); return (v >= (1 << (w - 1))) ? v - (1 << w) : v; endfunction

  task automatic ins(int op, int r);
    ins_valid = 1'b1; ins_op = 3'(op); ins_rpt = 4'(r);
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic fld(string r, int w, int d);
    chk(r, int'(fld_req), 1);
    chk(r, int'(fld_width), w);
    fld_valid = 1'b1; fld_data = 8'(d);
    @(negedge clk);
    fld_valid = 1'b0;
  endtask

  task automatic chk_regs(string r);
    for (int i = 0; i < 12; i++) chk(r, int'(coef[i*8 +: 8]), e_coef[i] & 255);
    chk(r, int'(amp), e_amp & 255);
    chk(r, int'(pitch), e_pitch & 255);
  endtask

  task automatic chk_commit(string r, int rp);
    chk_regs(r);
    chk("R13 strobe", int'(upd_valid), 1);
    chk("R13 rpt", int'(rpt), rp);
  endtask

  task automatic load_all(int a, int p, int seed, bit ext, int ad, int pd);
    extra = ext;
    ins(2, 7);
    fld("R2", 8, a);
    fld("R2", 8, p);
    for (int i = 0; i < 12; i++) fld("R2", 8, (i * 37 + seed) & 255);
    if (ext) begin
      fld("R2", 8, ad);
      fld("R2", 8, pd);
    end
    e_amp = a; e_pitch = p;
    for (int i = 0; i < 12; i++) e_coef[i] = (i * 37 + seed) & 255;
    chk_commit("R2 R5", 7);
  endtask

  task automatic load_pa(int a, int p);
    ins(1, 2);
    fld("R2", 8, a);
    fld("R2", 8, p);
    e_amp = a; e_pitch = p;
    chk_commit("R2", 2);
  endtask

  initial begin
    e_amp = 0; e_pitch = 64;
    for (int i = 0; i < 12; i++) e_coef[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_regs("R1");
    chk("R1 strobe", int'(upd_valid), 0);
    chk("R1 ready", int'(ins_ready), 1);
    chk("R1 noise", int'(noise), 0);

    load_all(154, 51, 5, 1'b0, 0, 0);
    @(negedge clk);
    chk("R13 strobe low", int'(upd_valid), 0);

    // R13 outputs held while fields are pending
    ins(1, 3);
    fld("R2", 8, 200);
    chk("R13 hold amp", int'(amp), e_amp);
    chk("R13 hold strobe", int'(upd_valid), 0);
    fld("R2", 8, 99);
    e_amp = 200; e_pitch = 99;
    chk_commit("R13", 3);

    // R3 R4 R5 sweep of partial load
    for (int v = 0; v < 64; v++) begin
      ins(3, 1 + v % 15);
      fld("R3", 8, v * 3);
      fld("R3", 8, v + 1);
      fld("R4", 3, v % 8);
      fld("R3", 5, v % 32);
      fld("R4", 4, v % 16);
      fld("R3", 6, v);
      for (int i = 0; i < 12; i++) e_coef[i] = 0;
      e_coef[4] = uexp(v % 8, 3);
      e_coef[5] = msbj(v % 32, 5);
      e_coef[6] = uexp(v % 16, 4);
      e_coef[7] = msbj(v, 6);
      e_amp = (v * 3) & 255; e_pitch = v + 1;
      chk_commit("R3 R4 R5", 1 + v % 15);
    end

    // R6 R7 MSB set, extra off
    load_all(10, 20, 11, 1'b0, 0, 0);
    for (int v = 0; v < 32; v++) begin
      ins(4, 1 + v % 15);
      fld("R6", 8, v * 5);
      fld("R6", 6, (v * 2) & 63);
      fld("R6", 6, 63 - v);
      e_amp = v * 5;
      e_coef[7] = (e_coef[7] & 3) | (((v * 2) & 63) << 2);
      e_coef[9] = (e_coef[9] & 3) | ((63 - v) << 2);
      e_coef[10] = 0; e_coef[11] = 0;
      chk_commit("R6 R7", 1 + v % 15);
      chk("R6 ready", int'(ins_ready), 1);
    end

    // R7 extra on: F5 loaded, B5 kept
    load_all(30, 40, 3, 1'b1, 0, 0);
    ins(4, 5);
    fld("R6", 8, 77);
    fld("R6", 6, 21);
    fld("R6", 6, 42);
    fld("R7", 8, 165);
    e_amp = 77;
    e_coef[7] = (e_coef[7] & 3) | (21 << 2);
    e_coef[9] = (e_coef[9] & 3) | (42 << 2);
    e_coef[11] = 165;
    chk_commit("R7", 5);
    extra = 1'b0;

    // R8 delta sweep with carries and wrap
    for (int ai = 0; ai < 4; ai++) begin
      for (int d = 0; d < 16; d++) begin
        int a0, p0, pd;
        a0 = (ai == 0) ? 31 : (ai == 1) ? 248 : (ai == 2) ? 0 : 126;
        p0 = ai * 60 + d;
        pd = (2 * d + 1) & 31;
        load_pa(a0, p0);
        ins(5, 9);
        fld("R8", 4, d);
        fld("R8", 5, pd);
        fld("R8", 4, d);
        fld("R8", 4, 15 - d);
        e_amp   = (a0 + sx(d, 4)) & 255;
        e_pitch = (p0 + sx(pd, 5)) & 255;
        e_coef[8] = (e_coef[8] + 4 * sx(d, 4)) & 255;
        e_coef[9] = (e_coef[9] + 4 * sx(15 - d, 4)) & 255;
        chk_commit("R8", 9);
      end
    end

    // R10 noise selection
    load_pa(50, 0);
    chk("R10 noise on", int'(noise), 1);

    // R9 pause
    ins(0, 4);
    e_amp = 0; e_pitch = 64;
    for (int i = 0; i < 12; i++) e_coef[i] = 0;
    chk_commit("R9", 4);
    chk("R10 noise off", int'(noise), 0);
    chk("R9 no field", int'(fld_req), 0);

    // R12 no-ops
    load_pa(9, 8);
    @(negedge clk);
    ins(1, 0);
    chk("R12 ready", int'(ins_ready), 1);
    chk("R12 no field", int'(fld_req), 0);
    chk("R12 strobe", int'(upd_valid), 0);
    chk_regs("R12");
    ins(6, 3);
    chk("R12 ready", int'(ins_ready), 1);
    chk("R12 no field", int'(fld_req), 0);
    chk("R12 strobe", int'(upd_valid), 0);
    ins(7, 15);
    chk("R12 no field", int'(fld_req), 0);
    chk_regs("R12");

    // R11 per-period deltas
    load_all(16, 2, 7, 1'b1, 3, 255);
    for (int t = 0; t < 3; t++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      e_amp = (e_amp + 3) & 255;
      e_pitch = (e_pitch + 255) & 255;
      chk_regs("R11");
      chk("R10 R11 noise", int'(noise), (e_pitch == 0) ? 1 : 0);
    end
    extra = 1'b0;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk_regs("R11 gated");
    extra = 1'b1;
    load_pa(100, 60);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk_regs("R11 cleared");
    extra = 1'b0;

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule